// File: doc/BRIEF.md
# AES-128 Iterative Round Sequencer

This block drives an iterative AES-128 engine that works on one 128-bit state register. The substitution, row-shift, column-mix and key-add units and the key expander sit outside it. Each transformation unit sees the current state on `cur_state` and returns its result. On every clock the sequencer decides which result becomes the next state, so a full round takes four cycles. Encryption and decryption share one fixed schedule. They differ only in the order of the four steps and in the order in which the round keys are taken.

After reset the sequencer first runs an initialization phase. It sends a one-cycle restart to the external key expander, along with the cipher key with its bytes reversed. It then waits a fixed number of cycles for the expansion to complete. At a fixed cycle it latches the eleven expanded round keys. In the next cycle it loads the remapped input block XORed with the first round key. Ten rounds follow. The last round leaves out column mixing, although the round key is still refreshed at that step position. A final output cycle maps the state back to the external byte order and raises `data_ready`. The result is then held until the next reset.

Top module: `aes_round_seq`

## Requirements
- R1: While `rst_n` is low and until the operation has completed, `data_ready` is 0; while `rst_n` is low, `kx_restart` is 0.
- R2: `kx_restart` is high for exactly one cycle, which is the first cycle after the synchronized reset release. `kx_key` always carries `key_in` with its bytes reversed (`key_in[127:120]` appears on `kx_key[7:0]`).
- R3: Round key i occupies `kx_words[128*i +: 128]`, for i = 0..10. The sequencer captures all of `kx_words` on the 98th clock edge after the synchronized reset release. Later changes on `kx_words` have no effect.
- R4: On the 99th edge the state is loaded with the remapped input XORed with round key 0 when encrypting, or with round key 10 when decrypting.
- R5: Byte remapping: internal byte 4*r+c (bits `[8*(4r+c) +: 8]`) takes external big-endian byte 4*c+r (bits `[127-8*(4c+r) -: 8]`) of `data_in`. `result` applies the inverse mapping.
- R6: In each encryption round the state takes the substitution result, then the row-shift result, then the column-mix result, then the key-add result, one per edge.
- R7: In each decryption round the state takes the row-shift result, then the substitution result, then the key-add result, then the column-mix result.
- R8: In round 10 the column-mix step leaves the state unchanged. The step still takes one cycle.
- R9: `round_key` is updated in the step just before key addition. Round n uses key n when encrypting and key 10-n when decrypting.
- R10: `data_ready` rises on the 140th clock edge after the synchronized reset release. At that point `result` equals the remapped final state.
- R11: Once `data_ready` is high, `data_ready`, `result`, `cur_state` and `round_key` hold until reset. A reset at any point restarts the whole sequence.
- R12: `enc_sel` is sampled in the first cycle after the synchronized reset release (1 = encrypt). Later changes have no effect on the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enc_sel | input | 1 | 1 = encrypt, 0 = decrypt |
| key_in | input | 128 | Cipher key, big-endian |
| data_in | input | 128 | Input block, column-ordered big-endian |
| result | output | 128 | Output block, column-ordered big-endian |
| data_ready | output | 1 | High once the result is valid |
| kx_restart | output | 1 | One-cycle restart pulse to the key expander |
| kx_key | output | 128 | Byte-reversed key for the key expander |
| kx_words | input | 1408 | Eleven expanded round keys, key i at bits 128*i |
| cur_state | output | 128 | Current state, fed to the transformation units |
| round_key | output | 128 | Current round key, fed to the key-add unit |
| op_encrypt | output | 1 | Latched direction, fed to the transformation units |
| sub_res | input | 128 | Substitution result of cur_state |
| shift_res | input | 128 | Row-shift result of cur_state |
| mix_res | input | 128 | Column-mix result of cur_state |
| add_res | input | 128 | cur_state XOR round_key |

## Verification
Every round feeds the next, so a wrong step, round or key index corrupts the state and cannot be undone. It shows up as a wrong `result` when `data_ready` rises on edge 140. If the phase counter is off, `data_ready` rises early or late, or the wrong snapshot of `kx_words` is captured. The bench uses transformation stand-ins that do not commute, so any swap in order changes the final value. It also lets `kx_words` carry valid keys only in a window around the capture cycle, so a late capture is seen.

// File: rtl/aes_seq_pkg.sv
package aes_seq_pkg;

  typedef enum logic [1:0] {
    PH_INIT,
    PH_RUN,
    PH_OUT,
    PH_DONE
  } phase_e;

  typedef enum logic [2:0] {
    SEL_HOLD,
    SEL_LOAD,
    SEL_SUB,
    SEL_SHIFT,
    SEL_MIX,
    SEL_ADD
  } state_sel_e;

  typedef enum logic [1:0] {
    MAP_TO_ROWS,
    MAP_TO_COLS,
    MAP_BYTE_REV
  } remap_e;

  localparam int STEP_W = 2;

endpackage

// File: rtl/aes_seq_remap.sv
module aes_seq_remap
  import aes_seq_pkg::*;
#(
  parameter remap_e MODE = MAP_TO_ROWS,
  parameter int     BLK  = 128
) (
  input  logic [BLK-1:0] din,
  output logic [BLK-1:0] dout
);

  localparam int NBYTES = BLK / 8;
  localparam int NROWS  = 4;
  localparam int NCOLS  = NBYTES / NROWS;

  generate
    if (MODE == MAP_BYTE_REV) begin : g_rev
      for (genvar i = 0; i < NBYTES; i++) begin : g_b
        assign dout[8*i +: 8] = din[BLK-1-8*i -: 8];
      end
    end else begin : g_grid
      for (genvar r = 0; r < NROWS; r++) begin : g_r
        for (genvar c = 0; c < NCOLS; c++) begin : g_c
          if (MODE == MAP_TO_ROWS) begin : g_in
            assign dout[8*(NCOLS*r+c) +: 8] = din[BLK-1-8*(NROWS*c+r) -: 8];
          end else begin : g_out
            assign dout[BLK-1-8*(NROWS*c+r) -: 8] = din[8*(NCOLS*r+c) +: 8];
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/aes_seq_keypick.sv
module aes_seq_keypick #(
  parameter int BLK    = 128,
  parameter int KWORDS = 11,
  parameter int IW     = 4
) (
  input  logic [BLK*KWORDS-1:0] words_flat,
  input  logic [IW-1:0]         idx,
  output logic [BLK-1:0]        word
);

  logic [BLK-1:0] words [KWORDS];

  generate
    for (genvar i = 0; i < KWORDS; i++) begin : g_w
      assign words[i] = words_flat[BLK*i +: BLK];
    end
  endgenerate

  always_comb begin
    word = '0;
    for (int i = 0; i < KWORDS; i++) begin
      if (idx == IW'(i)) word = words[i];
    end
  end

endmodule

// File: rtl/aes_seq_steps.sv
module aes_seq_steps
  import aes_seq_pkg::*;
#(
  parameter int N_ROUNDS    = 10,
  parameter int INIT_CYCLES = 99,
  parameter int RW          = $clog2(N_ROUNDS + 1)
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          enc_sel,
  output phase_e        phase,
  output state_sel_e    sel,
  output logic          rk_load,
  output logic [RW-1:0] rk_idx,
  output logic          ek_latch,
  output logic          restart,
  output logic          enc_q
);

  localparam int CW = $clog2(INIT_CYCLES);
  localparam logic [CW-1:0] CNT_LATCH = CW'(INIT_CYCLES - 2);
  localparam logic [CW-1:0] CNT_LOAD  = CW'(INIT_CYCLES - 1);
  localparam logic [RW-1:0] LAST_RND  = RW'(N_ROUNDS);

  phase_e            phase_q, phase_d;
  logic [RW-1:0]     rnd_q, rnd_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              enc_en;
  logic              last_rnd;

  assign phase    = phase_q;
  assign restart  = (phase_q == PH_INIT) && (cnt_q == '0);
  assign ek_latch = (phase_q == PH_INIT) && (cnt_q == CNT_LATCH);
  assign enc_en   = restart;
  assign last_rnd = (rnd_q == LAST_RND);

  // sequence progression
  always_comb begin
    phase_d = phase_q;
    rnd_d   = rnd_q;
    step_d  = step_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_INIT: begin
        if (cnt_q == CNT_LOAD) begin
          phase_d = PH_RUN;
          rnd_d   = RW'(1);
          step_d  = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      PH_RUN: begin
        step_d = step_q + STEP_W'(1);
        if (step_q == STEP_W'(3)) begin
          if (last_rnd) phase_d = PH_OUT;
          else          rnd_d   = rnd_q + RW'(1);
        end
      end
      PH_OUT:  phase_d = PH_DONE;
      default: phase_d = PH_DONE;
    endcase
  end

  // step decode: which result becomes the next state
  always_comb begin
    sel     = SEL_HOLD;
    rk_load = 1'b0;
    rk_idx  = '0;
    if (phase_q == PH_INIT && cnt_q == CNT_LOAD) begin
      sel     = SEL_LOAD;
      rk_load = 1'b1;
      rk_idx  = enc_q ? '0 : LAST_RND;
    end else if (phase_q == PH_RUN) begin
      if (enc_q) begin
        unique case (step_q)
          2'd0: sel = SEL_SUB;
          2'd1: sel = SEL_SHIFT;
          2'd2: begin
            sel     = last_rnd ? SEL_HOLD : SEL_MIX;
            rk_load = 1'b1;
            rk_idx  = rnd_q;
          end
          default: sel = SEL_ADD;
        endcase
      end else begin
        unique case (step_q)
          2'd0: sel = SEL_SHIFT;
          2'd1: begin
            sel     = SEL_SUB;
            rk_load = 1'b1;
            rk_idx  = LAST_RND - rnd_q;
          end
          2'd2: sel = SEL_ADD;
          default: sel = last_rnd ? SEL_HOLD : SEL_MIX;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      phase_q <= PH_INIT;
      rnd_q   <= '0;
      step_q  <= '0;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      rnd_q   <= rnd_d;
      step_q  <= step_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     enc_q <= 1'b1;
    else if (enc_en) enc_q <= enc_sel;
  end

endmodule

// File: rtl/aes_round_seq.sv
module aes_round_seq
  import aes_seq_pkg::*;
#(
  parameter int BLK         = 128,
  parameter int N_ROUNDS    = 10,
  parameter int INIT_CYCLES = 99
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        enc_sel,
  input  logic [BLK-1:0]              key_in,
  input  logic [BLK-1:0]              data_in,
  output logic [BLK-1:0]              result,
  output logic                        data_ready,
  output logic                        kx_restart,
  output logic [BLK-1:0]              kx_key,
  input  logic [BLK*(N_ROUNDS+1)-1:0] kx_words,
  output logic [BLK-1:0]              cur_state,
  output logic [BLK-1:0]              round_key,
  output logic                        op_encrypt,
  input  logic [BLK-1:0]              sub_res,
  input  logic [BLK-1:0]              shift_res,
  input  logic [BLK-1:0]              mix_res,
  input  logic [BLK-1:0]              add_res
);

  localparam int KWORDS = N_ROUNDS + 1;
  localparam int EKW    = BLK * KWORDS;
  localparam int RW     = $clog2(KWORDS);

  // reset: asserted asynchronously, released on the second clock edge
  logic rst_s1, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  phase_e        phase;
  state_sel_e    sel;
  logic          rk_load, ek_latch, restart, enc_q;
  logic [RW-1:0] rk_idx;

  aes_seq_steps #(
    .N_ROUNDS   (N_ROUNDS),
    .INIT_CYCLES(INIT_CYCLES),
    .RW         (RW)
  ) u_steps (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .enc_sel (enc_sel),
    .phase   (phase),
    .sel     (sel),
    .rk_load (rk_load),
    .rk_idx  (rk_idx),
    .ek_latch(ek_latch),
    .restart (restart),
    .enc_q   (enc_q)
  );

  logic [BLK-1:0] data_rows, result_cols;
  logic [BLK-1:0] state_q, state_d;
  logic [BLK-1:0] rk_q, key_pick;
  logic [EKW-1:0] ek_q;
  logic [BLK-1:0] result_q;
  logic           ready_q;
  logic           out_en;

  aes_seq_remap #(.MODE(MAP_TO_ROWS), .BLK(BLK)) u_map_in (
    .din (data_in),
    .dout(data_rows)
  );

  aes_seq_remap #(.MODE(MAP_TO_COLS), .BLK(BLK)) u_map_out (
    .din (state_q),
    .dout(result_cols)
  );

  aes_seq_remap #(.MODE(MAP_BYTE_REV), .BLK(BLK)) u_key_rev (
    .din (key_in),
    .dout(kx_key)
  );

  aes_seq_keypick #(.BLK(BLK), .KWORDS(KWORDS), .IW(RW)) u_pick (
    .words_flat(ek_q),
    .idx       (rk_idx),
    .word      (key_pick)
  );

  always_comb begin
    unique case (sel)
      SEL_LOAD:  state_d = data_rows ^ key_pick;
      SEL_SUB:   state_d = sub_res;
      SEL_SHIFT: state_d = shift_res;
      SEL_MIX:   state_d = mix_res;
      SEL_ADD:   state_d = add_res;
      default:   state_d = state_q;
    endcase
  end

  assign out_en = (phase == PH_OUT);

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) state_q <= '0;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      rk_q <= '0;
    else if (rk_load) rk_q <= key_pick;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)       ek_q <= '0;
    else if (ek_latch) ek_q <= kx_words;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      result_q <= '0;
      ready_q  <= 1'b0;
    end else if (out_en) begin
      result_q <= result_cols;
      ready_q  <= 1'b1;
    end
  end

  assign result     = result_q;
  assign data_ready = ready_q;
  assign kx_restart = restart & rst_sn;
  assign cur_state  = state_q;
  assign round_key  = rk_q;
  assign op_encrypt = enc_q;

endmodule

// File: rtl/aes_round_seq_chk.sv
module aes_round_seq_chk #(
  parameter int BLK = 128
) (
  input logic           clk,
  input logic           rst_n,
  input logic           data_ready,
  input logic           kx_restart,
  input logic [BLK-1:0] result,
  input logic [BLK-1:0] cur_state,
  input logic [BLK-1:0] round_key
);

  p_restart_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    kx_restart |=> !kx_restart)
    else $error("restart pulse longer than one cycle");

  p_restart_not_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    kx_restart |-> !data_ready)
    else $error("restart while ready");

  p_ready_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |=> data_ready)
    else $error("ready dropped");

  p_result_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |=> $stable(result))
    else $error("result moved after ready");

  p_state_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |=> ($stable(cur_state) && $stable(round_key)))
    else $error("state or key moved after ready");

endmodule

bind aes_round_seq aes_round_seq_chk #(.BLK(BLK)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .data_ready(data_ready),
  .kx_restart(kx_restart),
  .result    (result),
  .cur_state (cur_state),
  .round_key (round_key)
);

// File: tb/sim_aes_round_seq.sv
`timescale 1ns/1ps
module sim_aes_round_seq;

  localparam logic [127:0] C_SUB = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3211;

  logic           clk;
  logic           rst_n;
  logic           enc_sel;
  logic [127:0]   key_in, data_in;
  logic [127:0]   result;
  logic           data_ready, kx_restart, op_encrypt;
  logic [127:0]   kx_key, cur_state, round_key;
  logic [1407:0]  kx_words;
  logic [127:0]   sub_res, shift_res, mix_res, add_res;
  logic           ek_valid;

  int checks;
  int errors;

  aes_round_seq u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .enc_sel   (enc_sel),
    .key_in    (key_in),
    .data_in   (data_in),
    .result    (result),
    .data_ready(data_ready),
    .kx_restart(kx_restart),
    .kx_key    (kx_key),
    .kx_words  (kx_words),
    .cur_state (cur_state),
    .round_key (round_key),
    .op_encrypt(op_encrypt),
    .sub_res   (sub_res),
    .shift_res (shift_res),
    .mix_res   (mix_res),
    .add_res   (add_res)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [127:0] rotl(input logic [127:0] v, input int n);
    return (v << n) | (v >> (128 - n));
  endfunction

  function automatic logic [127:0] toy_word(input logic [127:0] k, input int i);
    return rotl(k, 8*i + 3) ^ {16{8'(i)}};
  endfunction

  // non-commuting stand-ins for the transformation units
  assign sub_res   = cur_state + C_SUB;
  assign shift_res = rotl(cur_state, 8);
  assign mix_res   = cur_state * 128'd3;
  assign add_res   = cur_state ^ round_key;

  always_comb begin
    for (int i = 0; i < 11; i++) begin
      kx_words[128*i +: 128] = ek_valid ? toy_word(kx_key, i) : {4{32'hdead_beef}};
    end
  end

  // R5 mapping, written from the requirement
  function automatic logic [127:0] to_rows(input logic [127:0] d);
    logic [127:0] q;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        q[8*(4*r+c) +: 8] = d[127-8*(4*c+r) -: 8];
    return q;
  endfunction

  function automatic logic [127:0] to_cols(input logic [127:0] d);
    logic [127:0] q;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        q[127-8*(4*c+r) -: 8] = d[8*(4*r+c) +: 8];
    return q;
  endfunction

  function automatic logic [127:0] rev_bytes(input logic [127:0] d);
    logic [127:0] q;
    for (int i = 0; i < 16; i++) q[8*i +: 8] = d[127-8*i -: 8];
    return q;
  endfunction

  // R4 R6 R7 R8 R9 model
  function automatic logic [127:0] model(input bit enc, input logic [127:0] k,
                                         input logic [127:0] d);
    logic [127:0] kr, s;
    kr = rev_bytes(k);
    s  = to_rows(d) ^ toy_word(kr, enc ? 0 : 10);
    for (int r = 1; r <= 10; r++) begin
      if (enc) begin
        s = s + C_SUB;
        s = rotl(s, 8);
        if (r < 10) s = s * 128'd3;
        s = s ^ toy_word(kr, r);
      end else begin
        s = rotl(s, 8);
        s = s + C_SUB;
        s = s ^ toy_word(kr, 10 - r);
        if (r < 10) s = s * 128'd3;
      end
    end
    return to_cols(s);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input bit enc, input logic [127:0] k, input logic [127:0] d,
                        input bit flip_dir, input int abort_at);
    int rs;
    int pulses;
    logic [127:0] exp;
    logic [127:0] held;
    @(negedge clk);
    rst_n    = 1'b0;
    enc_sel  = enc;
    key_in   = k;
    data_in  = d;
    ek_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(data_ready == 1'b0 && kx_restart == 1'b0, "R1 in reset",
        {126'd0, data_ready, kx_restart}, 128'd0);
    rst_n  = 1'b1;
    rs     = 0;
    pulses = 0;
    exp    = model(enc, k, d);
    for (int n = 1; n <= 142; n++) begin
      @(negedge clk);
      if (kx_restart) begin
        pulses++;
        if (rs == 0) rs = n;
      end
      ek_valid = (rs > 0) && (n - rs >= 48) && (n - rs <= 103);
      if (n == 2) begin
        chk(kx_restart == 1'b1, "R2 restart in first cycle", {127'd0, kx_restart}, 128'd1);
        chk(kx_key == rev_bytes(k), "R2 key reversal", kx_key, rev_bytes(k));
      end
      if (flip_dir && n == 10) enc_sel = ~enc;
      if (abort_at > 0 && n == abort_at) begin
        rst_n = 1'b0;
        @(negedge clk);
        chk(data_ready == 1'b0 && kx_restart == 1'b0, "R11 abort by reset",
            {126'd0, data_ready, kx_restart}, 128'd0);
        return;
      end
      if (n == 141)
        chk(data_ready == 1'b0, "R1 R10 not ready at edge 139", {127'd0, data_ready}, 128'd0);
    end
    chk(data_ready == 1'b1, "R10 ready at edge 140", {127'd0, data_ready}, 128'd1);
    chk(result == exp, enc ? "R3 R4 R5 R6 R8 R9 R12 encrypt result"
                           : "R3 R4 R5 R7 R8 R9 R12 decrypt result", result, exp);
    chk(pulses == 1, "R2 single restart pulse", 128'(pulses), 128'd1);
    held    = result;
    key_in  = ~k;
    data_in = ~d;
    enc_sel = ~enc_sel;
    repeat (20) @(negedge clk);
    chk(data_ready == 1'b1 && result == held, "R11 result held", result, held);
  endtask

  initial begin
    checks   = 0;
    errors   = 0;
    rst_n    = 1'b0;
    enc_sel  = 1'b1;
    key_in   = '0;
    data_in  = '0;
    ek_valid = 1'b0;
    for (int p = 0; p < 4; p++) begin
      logic [127:0] kk, dd;
      kk = {4{32'h1357_9bdf}} ^ (128'(p) << (32 * p)) ^ 128'(p * 7919);
      dd = {8{16'h0f1e}} + (128'(p + 1) << (29 * p)) ^ {16{8'(p * 37)}};
      run_op(1'b1, kk, dd, 1'b0, 0);
      run_op(1'b0, kk, dd, 1'b0, 0);
    end
    // R12: direction change after sampling is ignored
    run_op(1'b1, 128'h0011_2233_4455_6677_8899_aabb_ccdd_eeff,
           128'h0f0e_0d0c_0b0a_0908_0706_0504_0302_0100, 1'b1, 0);
    run_op(1'b0, 128'h0011_2233_4455_6677_8899_aabb_ccdd_eeff,
           128'h0f0e_0d0c_0b0a_0908_0706_0504_0302_0100, 1'b1, 0);
    // R11: reset in the middle of the rounds, then a full run
    run_op(1'b1, 128'hcafe_f00d_0000_1111_2222_3333_4444_5555,
           128'h8000_0000_0000_0000_0000_0000_0000_0001, 1'b0, 120);
    run_op(1'b0, 128'hcafe_f00d_0000_1111_2222_3333_4444_5555,
           128'h8000_0000_0000_0000_0000_0000_0000_0001, 1'b0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule